// File: doc/BRIEF.md
# Arrival-Aware Hybrid Completion Adder

This block is the final two-operand adder that sits behind a multiplier's partial-product reduction tree. It receives the tree's redundant result as two 32-bit vectors, one of sums and one of carries, and resolves them into a single two's-complement word plus a carry out of the top bit.

The 32 bit positions do not all arrive at the same time, so the adder uses a different structure for each region. The low byte arrives first and is resolved by a plain ripple chain. The middle sixteen bits arrive last and go through a carry-lookahead section made of five blocks of 2, 4, 4, 4 and 2 bits. Each block forms its own group generate and propagate terms, and a second lookahead level combines these terms across the blocks. The top byte is computed twice in advance, once assuming no incoming carry and once assuming one. A single multiplexer picks between the two results, using only the carry that leaves bit 23.

All of the arithmetic is combinational. A parameter places a register on the outputs (the default), which gives a latency of one clock cycle.

Top module: `csv_final_adder`

## Requirements
- R1: Each cycle, `{carry_o, total_o}` equals the 33-bit sum of `sv_in` and `cv_in` taken as unsigned numbers. With `REG_OUT=1` the result appears one clock cycle after the inputs.
- R2: A carry produced anywhere in bits 0 to 7 enters bit 8 correctly. For example, 0x000000FF + 0x00000001 gives 0x00000100.
- R3: The carry leaving bit 23 equals the carry of the 24-bit sum of the two low 24-bit fields. A carry that enters at bit 8 and propagates through all sixteen middle bits must reach bit 24.
- R4: Carries cross every internal lookahead block edge, at bits 10, 14, 18 and 22. A block whose bits all propagate passes its incoming carry through unchanged. Any other block outputs its own generate term.
- R5: The two precomputed top-byte candidates, each taken with its carry out, differ by exactly one. The chosen candidate makes the top byte and the carry out correct, including the case where the top byte overflows to zero.
- R6: Bits 24 to 31 of either input have no effect on bits 0 to 23 of the result.
- R7: While `rst_n` is low, `total_o` and `carry_o` are held at zero. After a new input is applied, the outputs keep the previous result until the next rising edge of `clk`.
- R8: 0xFFFFFFFF + 0x00000001 gives `total_o` = 0 and `carry_o` = 1. 0xFFFFFFFF + 0xFFFFFFFF gives 0xFFFFFFFE with `carry_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register and the checks |
| rst_n | input | 1 | Active-low asynchronous reset that clears the outputs |
| sv_in | input | 32 | Sum vector from the reduction tree |
| cv_in | input | 32 | Carry vector from the reduction tree, already aligned to its bit weights |
| total_o | output | 32 | Resolved result, modulo 2^32 |
| carry_o | output | 1 | Carry out of bit 31 |

## Verification
The directed vectors place a single carry so that it must travel across each region boundary and each lookahead block edge. An adder that dropped a hand-off would return a result with a whole power of two missing, for example 0x00000000 in place of 0x00000400. Vectors made of operand pairs x and ~x drive full propagation through all bits. If the top byte were selected from the wrong candidate, the result would be off by exactly 2^24, and the wrap-to-zero case would also lose the carry out. A pair of runs that share their low 24 bits but differ in the top byte shows whether the select leaks high bits back into the low result. The single-cycle latency check catches an output that is registered twice or not registered at all.

// File: rtl/hca_pkg.sv
package hca_pkg;

  // Number of lookahead blocks in the middle (latest-arriving) region.
  localparam int MID_NBLK = 5;

  // Width of middle block k: narrow blocks at both ends, wide blocks inside.
  function automatic int mid_blk_w(input int k);
    case (k)
      0:       return 2;
      1, 2, 3: return 4;
      default: return 2;
    endcase
  endfunction

  // Offset of middle block k within the middle region.
  function automatic int mid_blk_base(input int k);
    int acc;
    acc = 0;
    for (int i = 0; i < k; i++) acc += mid_blk_w(i);
    return acc;
  endfunction

  localparam int MID_TOTAL = mid_blk_base(MID_NBLK);

  // Carry into position hi, given carry cin into position lo,
  // in flat two-level lookahead form (no ripple between positions).
  function automatic logic span_carry(input logic [MID_TOTAL-1:0] g,
                                      input logic [MID_TOTAL-1:0] p,
                                      input logic cin,
                                      input int lo, input int hi);
    logic acc, term;
    acc = cin;
    for (int k = lo; k < hi; k++) acc = acc & p[k];
    for (int k = lo; k < hi; k++) begin
      term = g[k];
      for (int m = k + 1; m < hi; m++) term = term & p[m];
      acc = acc | term;
    end
    return acc;
  endfunction

  // Group propagate over positions lo..hi-1.
  function automatic logic span_prop(input logic [MID_TOTAL-1:0] p,
                                     input int lo, input int hi);
    logic acc;
    acc = 1'b1;
    for (int k = lo; k < hi; k++) acc = acc & p[k];
    return acc;
  endfunction

  // One full-adder step: returns {carry, sum}.
  function automatic logic [1:0] fa_step(input logic x, input logic y,
                                         input logic c);
    return {(x & y) | (c & (x ^ y)), x ^ y ^ c};
  endfunction

endpackage

// File: rtl/hca_ripple.sv
module hca_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  import hca_pkg::*;

  logic       chain;
  logic [1:0] step;

  always_comb begin
    chain = cin;
    step  = '0;
    for (int i = 0; i < W; i++) begin
      step  = fa_step(a[i], b[i], chain);
      s[i]  = step[0];
      chain = step[1];
    end
    cout = chain;
  end

endmodule

// File: rtl/hca_cla_mid.sv
module hca_cla_mid (
  input  logic [hca_pkg::MID_TOTAL-1:0] a,
  input  logic [hca_pkg::MID_TOTAL-1:0] b,
  input  logic                          cin,
  output logic [hca_pkg::MID_TOTAL-1:0] s,
  output logic                          cout,
  output logic [hca_pkg::MID_NBLK-1:0]  grp_g,
  output logic [hca_pkg::MID_NBLK-1:0]  grp_p,
  output logic [hca_pkg::MID_NBLK:0]    blk_c
);
  import hca_pkg::*;

  localparam int W  = MID_TOTAL;
  localparam int NB = MID_NBLK;

  logic [W-1:0] bit_g, bit_p;
  assign bit_g = a & b;
  assign bit_p = a ^ b;

  // First level: each block forms its group terms and its internal carries.
  for (genvar k = 0; k < NB; k++) begin : g_blk
    localparam int BW   = mid_blk_w(k);
    localparam int BASE = mid_blk_base(k);

    assign grp_g[k] = span_carry(bit_g, bit_p, 1'b0, BASE, BASE + BW);
    assign grp_p[k] = span_prop(bit_p, BASE, BASE + BW);

    for (genvar j = 0; j < BW; j++) begin : g_pos
      assign s[BASE+j] = bit_p[BASE+j]
                       ^ span_carry(bit_g, bit_p, blk_c[k], BASE, BASE + j);
    end
  end

  // Second level: lookahead over the group terms to produce block carries.
  logic term;
  always_comb begin
    blk_c    = '0;
    blk_c[0] = cin;
    term     = 1'b0;
    for (int j = 1; j <= NB; j++) begin
      blk_c[j] = cin;
      for (int k = 0; k < j; k++) blk_c[j] = blk_c[j] & grp_p[k];
      for (int k = 0; k < j; k++) begin
        term = grp_g[k];
        for (int m = k + 1; m < j; m++) term = term & grp_p[m];
        blk_c[j] = blk_c[j] | term;
      end
    end
  end

  assign cout = blk_c[NB];

endmodule

// File: rtl/hca_csel_hi.sv
module hca_csel_hi #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         cout,
  output logic [W-1:0] cand0,
  output logic [W-1:0] cand1,
  output logic         cout0,
  output logic         cout1
);

  // Both carry-in assumptions are evaluated while the middle region settles.
  hca_ripple #(.W(W)) u_cin0 (
    .a(a), .b(b), .cin(1'b0), .s(cand0), .cout(cout0)
  );

  hca_ripple #(.W(W)) u_cin1 (
    .a(a), .b(b), .cin(1'b1), .s(cand1), .cout(cout1)
  );

  // Single multiplexer stage driven by the late carry.
  assign s    = sel ? cand1 : cand0;
  assign cout = sel ? cout1 : cout0;

endmodule

// File: rtl/csv_final_adder.sv
module csv_final_adder #(
  parameter int WIDTH   = 32,
  parameter int LOW_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sv_in,
  input  logic [WIDTH-1:0] cv_in,
  output logic [WIDTH-1:0] total_o,
  output logic             carry_o
);
  import hca_pkg::*;

  localparam int MID_W = MID_TOTAL;
  localparam int HI_LO = LOW_W + MID_W;
  localparam int HI_W  = WIDTH - HI_LO;
  localparam int NB    = MID_NBLK;

  // Named hand-off points between the three regions.
  logic [LOW_W-1:0] lo_sum;
  logic             c_lo2mid;
  logic [MID_W-1:0] mid_sum;
  logic             c_mid2hi;
  logic [HI_W-1:0]  hi_sum, hi_cand0, hi_cand1;
  logic             hi_cout, hi_cout0, hi_cout1;
  logic [NB-1:0]    grp_g, grp_p;
  logic [NB:0]      blk_c;
  logic [WIDTH-1:0] sum_comb;
  logic             cout_comb;

  // Early low byte: ripple chain, no carry in.
  hca_ripple #(.W(LOW_W)) u_lo (
    .a    (sv_in[LOW_W-1:0]),
    .b    (cv_in[LOW_W-1:0]),
    .cin  (1'b0),
    .s    (lo_sum),
    .cout (c_lo2mid)
  );

  // Critical middle region: two-level variable-block lookahead.
  hca_cla_mid u_mid (
    .a     (sv_in[HI_LO-1:LOW_W]),
    .b     (cv_in[HI_LO-1:LOW_W]),
    .cin   (c_lo2mid),
    .s     (mid_sum),
    .cout  (c_mid2hi),
    .grp_g (grp_g),
    .grp_p (grp_p),
    .blk_c (blk_c)
  );

  // Upper byte: precomputed pair, selected by carry out of the middle.
  hca_csel_hi #(.W(HI_W)) u_hi (
    .a     (sv_in[WIDTH-1:HI_LO]),
    .b     (cv_in[WIDTH-1:HI_LO]),
    .sel   (c_mid2hi),
    .s     (hi_sum),
    .cout  (hi_cout),
    .cand0 (hi_cand0),
    .cand1 (hi_cand1),
    .cout0 (hi_cout0),
    .cout1 (hi_cout1)
  );

  assign sum_comb  = {hi_sum, mid_sum, lo_sum};
  assign cout_comb = hi_cout;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        total_o <= '0;
        carry_o <= 1'b0;
      end else begin
        total_o <= sum_comb;
        carry_o <= cout_comb;
      end
    end

    // R1
    sum_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ({carry_o, total_o} == $past({1'b0, sv_in} + {1'b0, cv_in})));
  end else begin : g_comb
    always_comb begin
      total_o = sum_comb;
      carry_o = cout_comb;
    end

    // R1
    sum_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      {carry_o, total_o} == ({1'b0, sv_in} + {1'b0, cv_in}));
  end

  // Reference partial sums used only by the checks below.
  logic [LOW_W:0] lo_ref;
  logic [HI_LO:0] mid_ref;
  assign lo_ref  = {1'b0, sv_in[LOW_W-1:0]} + {1'b0, cv_in[LOW_W-1:0]};
  assign mid_ref = {1'b0, sv_in[HI_LO-1:0]} + {1'b0, cv_in[HI_LO-1:0]};

  // R2
  lo_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_lo2mid == lo_ref[LOW_W]) && (lo_sum == lo_ref[LOW_W-1:0]));

  // R3
  mid_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mid2hi == mid_ref[HI_LO]) && ({mid_sum, lo_sum} == mid_ref[HI_LO-1:0]));

  for (genvar k = 0; k < NB; k++) begin : g_blkchk
    // R4
    blk_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_p[k] |-> (blk_c[k+1] == blk_c[k]));
    // R4
    blk_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_p[k] |-> (blk_c[k+1] == grp_g[k]));
  end

  // R5
  hi_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {hi_cout1, hi_cand1} == ({hi_cout0, hi_cand0} + {{HI_W{1'b0}}, 1'b1}));

endmodule

// File: tb/csv_final_adder_test.sv
`timescale 1ns/1ps
module csv_final_adder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  wire  [31:0] res;
  wire         co;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  csv_final_adder uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .sv_in   (a),
    .cv_in   (b),
    .total_o (res),
    .carry_o (co)
  );

  // Bit-serial reference: 33-bit unsigned sum.
  function automatic logic [32:0] ref_add(input logic [31:0] x, input logic [31:0] y);
    logic [32:0] r;
    int          cnt;
    logic        c;
    r = '0;
    c = 1'b0;
    for (int i = 0; i < 32; i++) begin
      cnt  = int'(x[i]) + int'(y[i]) + int'(c);
      r[i] = cnt[0];
      c    = cnt[1];
    end
    r[32] = c;
    return r;
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [31:0] x, input logic [31:0] y, input string req);
    @(negedge clk);
    a = x;
    b = y;
    @(negedge clk);
    check(req, {co, res}, ref_add(x, y));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] low_keep;
    logic [31:0] rx, ry;
    void'($urandom(32'd20061));

    // R7: outputs held at zero during reset, even with live inputs.
    a = 32'hFFFF_FFFF;
    b = 32'h0000_0001;
    repeat (3) @(negedge clk);
    check("R7 reset value", {co, res}, 33'h0);
    rst_n = 1'b1;

    // R8: all ones plus one, and all ones plus all ones.
    run_vec(32'hFFFF_FFFF, 32'h0000_0001, "R8 ones+1");
    check("R8 ones+1 literal", {co, res}, 33'h1_0000_0000);
    run_vec(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 ones+ones");
    check("R8 ones+ones literal", {co, res}, {1'b1, 32'hFFFF_FFFE});

    // R2: carries leaving the low byte.
    run_vec(32'h0000_00FF, 32'h0000_0001, "R2 low byte wrap");
    check("R2 low byte literal", {co, res}, 33'h0_0000_0100);
    run_vec(32'h0000_007F, 32'h0000_0081, "R2 low byte split");

    // R4: carry generated at bit 8 propagating across each block edge.
    for (int e = 0; e < 4; e++) begin
      int p;
      p = 10 + 4 * e;
      run_vec((32'd1 << p) - (32'd1 << 8), 32'd1 << 8, "R4 block edge");
      check("R4 block edge literal", {co, res}, {1'b0, 32'd1 << p});
    end

    // R3: full propagation through the middle into bit 24.
    run_vec(32'h00FF_FFFF, 32'h0000_0001, "R3 mid full run");
    check("R3 mid full run literal", {co, res}, 33'h0_0100_0000);
    run_vec(32'h00FF_FF80, 32'h0000_0080, "R3 low-to-high");
    run_vec(32'h0080_0000, 32'h0080_0000, "R3 bit23 generate");

    // R5: upper byte with and without incoming carry, and wrap to zero.
    run_vec(32'hFF80_0000, 32'h0080_0000, "R5 top wrap");
    check("R5 top wrap literal", {co, res}, 33'h1_0000_0000);
    run_vec(32'h1200_0000, 32'h3400_0000, "R5 no carry");
    run_vec(32'h7F80_0000, 32'h0080_0000, "R5 carry into top");

    // R6: changing only bits 24..31 leaves bits 0..23 unchanged.
    for (int i = 0; i < 20; i++) begin
      rx = $urandom;
      ry = $urandom;
      run_vec(rx, ry, "R6 first");
      low_keep = res[23:0];
      run_vec({8'($urandom), rx[23:0]}, {8'($urandom), ry[23:0]}, "R6 second");
      check("R6 low 24 bits unchanged", {9'h0, res[23:0]}, {9'h0, low_keep});
    end

    // R7: output holds until the next rising edge.
    run_vec(32'd5, 32'd6, "R7 before");
    @(negedge clk);
    a = 32'd10;
    b = 32'd20;
    #1;
    check("R7 holds old result", {co, res}, 33'd11);
    @(negedge clk);
    check("R7 new result after edge", {co, res}, 33'd30);

    // R1: random and structured propagate-heavy patterns.
    for (int i = 0; i < 400; i++) begin
      rx = $urandom;
      case (i % 4)
        0: ry = $urandom;
        1: ry = ~rx;
        2: ry = ~rx + 32'd1;
        default: ry = $urandom & $urandom & $urandom;
      endcase
      run_vec(rx, ry, "R1 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule